// File: doc/BRIEF.md
# Boot-Override Bus Decoder with Parallel Port

This block sits on the address bus of an 8-bit console CPU, between the processor and the rest of the machine. It watches the upper address lines and picks out two internal resources: a small boot ROM that answers in the 1xxx and 3xxx pages, and an 8-bit parallel I/O port that answers at 4800-4FFF. While either one is addressed, the block takes the bus for itself. It drops the console/cartridge enable and rewrites the high address lines sent on to the console, so the console only ever sees a harmless access in 4800-4FFF.

Two bits of the port steer the decoder.

- **Decoder-enable bit (bit 0).** The port pins come up as inputs after reset, and the pulled-up pins read as 1, so decoding starts enabled. Driving this bit to 0 turns off every decode, including the port's own. The port can then no longer be written, so it stays off until the next reset.
- **Override bit (bit 1).** This bit also starts out high. While it is high, the whole 8000-FFFF range goes to the boot ROM, so the reset and interrupt vectors are taken from it. Boot code clears the bit to hand the cartridge back, and can set it again whenever it needs to.

A third input bit (bit 2) carries the copy/play mode strap. Software reads it through the port's data register.

Top module: `boot_bus_decoder`

## Requirements
- R1: With decoding enabled, `rom_sel` is 1 for CPU addresses 1000-1FFF and 3000-3FFF, and 0 for other addresses outside 8000-FFFF.
- R2: With decoding enabled, `port_sel` is 1 exactly for addresses 4800-4FFF. Addresses 4000-47FF select nothing.
- R3: A synchronous reset clears the direction and data registers. All pins are then inputs (`pin_oe` = 0), and with pins pulled high both decoding and the override are active.
- R4: While the effective level of bit 1 is 1 and decoding is enabled, every address with A15 = 1 selects the ROM and drops `con_en`.
- R5: Writing 0 to bit 0 while its direction bit is 1 disables all decoding: no ROM, no port, no override. Later port writes have no effect, and only a reset restores decoding.
- R6: Bit 1 can be changed at any time through the port. Clearing it returns 8000-FFFF to the console and leaves the 1xxx/3xxx ROM decode enabled.
- R7: While the ROM or the port is selected, `con_en` is 0 and `con_addr` equals {5'b01001, A10..A0}, which is inside 4800-4FFF.
- R8: `rom_oe` is 1 only when `rom_sel`, `cpu_m2` and `cpu_rw` (1 = read) are all 1.
- R9: Inside the port window, A0 = 0 addresses the data register and A0 = 1 addresses the direction register. A direction bit of 1 makes that pin an output: `pin_oe` equals the direction register and `pin_out` equals the data register.
- R10: A read of the data register returns the data register value on output bits and `pin_in` on input bits; this is how the mode strap on bit 2 is read. `cpu_rdata` is 0 when the port is not being read.
- R11: When nothing internal is selected, `con_en` is 1 and `con_addr` equals `cpu_addr`.
- R12: A port register is written only on a clock edge where the port is selected, `cpu_m2` = 1 and `cpu_rw` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU read/write, 1 = read |
| cpu_m2 | input | 1 | CPU bus phase strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Port read data, 0 when the port is not being read |
| rom_sel | output | 1 | Boot ROM region selected |
| rom_oe | output | 1 | Qualified boot ROM output enable |
| port_sel | output | 1 | I/O port window selected |
| con_addr | output | 16 | Address presented to the console |
| con_en | output | 1 | Console/cartridge enable |
| pin_in | input | 8 | External port pin levels |
| pin_out | output | 8 | Port pin drive values |
| pin_oe | output | 8 | Port pin output enables |

## Verification
The decode, override, address remap, ROM enable and read data are all combinational. They are due in the same cycle as the address and strobes, so the bench applies each vector and samples 1 ns later, well before the next edge. A port write takes effect at the first rising edge where the write strobes are valid. Its results on `pin_out`, `pin_oe` and the decoder controls are therefore checked after the following falling edge, once the strobes have been removed. The lockout and the override change are checked on the accesses that follow that edge.

// File: rtl/boot_bus_pkg.sv
package boot_bus_pkg;

    localparam int ADDR_W = 16;
    localparam int PAGE_W = 5;                  // A15..A11 drive all decoding
    localparam logic [PAGE_W-1:0] SAFE_PAGE = 5'b01001; // 4800-4FFF window

    typedef struct packed {
        logic rom;
        logic port;
    } bus_sel_t;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } port_reg_e;

    // Boot ROM pages 1xxx and 3xxx
    function automatic logic is_rom_page(input logic [PAGE_W-1:0] page);
        return (page[4:1] == 4'h1) || (page[4:1] == 4'h3);
    endfunction

    // 4000-4FFF qualified by A11
    function automatic logic is_port_page(input logic [PAGE_W-1:0] page);
        return (page[4:1] == 4'h4) && page[0];
    endfunction

endpackage

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
    import boot_bus_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    input  logic              dec_en,
    input  logic              ovr_en,
    output bus_sel_t          sel
);
    logic rom_hit;
    logic port_hit;

    always_comb begin
        rom_hit  = is_rom_page(page) || (ovr_en && page[PAGE_W-1]);
        port_hit = is_port_page(page);
        sel.rom  = dec_en && rom_hit;
        sel.port = dec_en && port_hit;
    end

    // R1 R2
    always_comb begin
        sel_exclusive_chk: assert (!(sel.rom && sel.port));
    end

endmodule

// File: rtl/boot_bus_remap.sv
module boot_bus_remap
    import boot_bus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_in,
    input  bus_sel_t          sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic              con_en
);
    localparam int LOW_W = ADDR_W - PAGE_W;

    logic internal;

    always_comb begin
        internal = sel.rom || sel.port;
        con_en   = !internal;
        addr_out = internal ? {SAFE_PAGE, addr_in[LOW_W-1:0]} : addr_in;
    end

endmodule

// File: rtl/boot_io_port.sv
module boot_io_port
    import boot_bus_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  port_reg_e         reg_idx,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] pin_level,
    output logic [PORT_W-1:0] rd_view
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            if (reg_idx == REG_DIR) dir_q  <= wdata;
            else                    data_q <= wdata;
        end
    end

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        assign pin_level[i] = dir_q[i] ? data_q[i] : pin_in[i];
    end

    assign rd_view = (reg_idx == REG_DIR) ? dir_q : pin_level;

    // R3
    dir_reset_chk: assert property (@(posedge clk) rst |=> (dir_q == '0));

    // R12
    hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(dir_q) && $stable(data_q)));

endmodule

// File: rtl/boot_bus_decoder.sv
module boot_bus_decoder
    import boot_bus_pkg::*;
#(
    parameter int PORT_W  = 8,
    parameter int DEC_BIT = 0,
    parameter int OVR_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_m2,
    input  logic [PORT_W-1:0] cpu_wdata,
    output logic [PORT_W-1:0] cpu_rdata,
    output logic              rom_sel,
    output logic              rom_oe,
    output logic              port_sel,
    output logic [15:0]       con_addr,
    output logic              con_en,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    localparam int LOW_W = ADDR_W - PAGE_W;

    bus_sel_t          sel;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] pin_level;
    logic [PORT_W-1:0] rd_view;
    logic              dec_en;
    logic              ovr_en;
    logic              port_wr;
    port_reg_e         reg_idx;

    assign dec_en  = pin_level[DEC_BIT];
    assign ovr_en  = pin_level[OVR_BIT];
    assign reg_idx = port_reg_e'(cpu_addr[0]);
    assign port_wr = sel.port && cpu_m2 && !cpu_rw;

    boot_addr_decode u_decode (
        .page   (cpu_addr[ADDR_W-1:LOW_W]),
        .dec_en (dec_en),
        .ovr_en (ovr_en),
        .sel    (sel)
    );

    boot_bus_remap u_remap (
        .addr_in  (cpu_addr),
        .sel      (sel),
        .addr_out (con_addr),
        .con_en   (con_en)
    );

    boot_io_port #(.PORT_W(PORT_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (port_wr),
        .reg_idx   (reg_idx),
        .wdata     (cpu_wdata),
        .pin_in    (pin_in),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pin_level (pin_level),
        .rd_view   (rd_view)
    );

    assign rom_sel   = sel.rom;
    assign port_sel  = sel.port;
    assign rom_oe    = sel.rom && cpu_m2 && cpu_rw;
    assign pin_out   = data_q;
    assign pin_oe    = dir_q;
    assign cpu_rdata = (sel.port && cpu_rw) ? rd_view : '0;

    // R5
    lockout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_q[DEC_BIT] && !data_q[DEC_BIT]) |=> (!rom_sel && !port_sel));

    // R4
    vector_override_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_en && ovr_en && cpu_addr[15]) |-> !con_en);

    // R7
    safe_window_chk: assert property (@(posedge clk) disable iff (rst)
        !con_en |-> (con_addr[15:11] == SAFE_PAGE));

    // R8
    rom_oe_qual_chk: assert property (@(posedge clk) disable iff (rst)
        rom_oe |-> (cpu_m2 && cpu_rw && rom_sel));

    // R11
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        con_en |-> (con_addr == cpu_addr));

endmodule

// File: tb/boot_bus_decoder_tb.sv
module boot_bus_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rw = 1'b1;
    logic        cpu_m2 = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        rom_sel, rom_oe, port_sel, con_en;
    logic [15:0] con_addr;
    logic [7:0]  pin_in = 8'hFF;
    logic [7:0]  pin_out, pin_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    boot_bus_decoder u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_m2(cpu_m2), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .rom_sel(rom_sel), .rom_oe(rom_oe), .port_sel(port_sel),
        .con_addr(con_addr), .con_en(con_en), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {addr, rw, m2, rom, port, con_en, con_addr, oe}
    localparam int NV = 10;
    localparam logic [37:0] VEC [NV] = '{
        {16'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h4A34, 1'b1},
        {16'h3FFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h4FFF, 1'b0},
        {16'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h2000, 1'b0},
        {16'h4800, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h4800, 1'b0},
        {16'h47FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h47FF, 1'b0},
        {16'hFFFC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h4FFC, 1'b1},
        {16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h4800, 1'b0},
        {16'h0FFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0FFF, 1'b0},
        {16'h4FFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h4FFF, 1'b0},
        {16'h5000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h5000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rw = 1'b1; cpu_m2 = 1'b1;
        #1;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic m2);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rw = 1'b0; cpu_m2 = m2;
        @(negedge clk);
        cpu_rw = 1'b1; cpu_m2 = 1'b0; cpu_addr = 16'h0000;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R3 reset state
        chk("R3 pin_oe", pin_oe, 8'h00);
        bus_read(16'h4801);
        chk("R3 dir readback", cpu_rdata, 8'h00);

        // Decode table walk (R1 R2 R4 R7 R8 R11)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cpu_addr = VEC[i][37:22]; cpu_rw = VEC[i][21]; cpu_m2 = VEC[i][20];
            #1;
            chk("R1 R4 rom_sel", rom_sel, VEC[i][19]);
            chk("R2 port_sel", port_sel, VEC[i][18]);
            chk("R7 R11 con_en", con_en, VEC[i][17]);
            chk("R7 R11 con_addr", con_addr, VEC[i][16:1]);
            chk("R8 rom_oe", rom_oe, VEC[i][0]);
        end

        // R10 input read, R6 override low through input pin
        pin_in = 8'hA5;
        bus_read(16'h4800);
        chk("R10 input read", cpu_rdata, 8'hA5);
        bus_read(16'hFFFC);
        chk("R6 ovr pin low", con_en, 1'b1);
        pin_in = 8'hFF;
        bus_read(16'h2000);
        chk("R10 no read data", cpu_rdata, 8'h00);

        // R9 register select and direction
        bus_write(16'h4800, 8'h03, 1'b1);
        chk("R9 data as input only", pin_oe, 8'h00);
        bus_write(16'h4801, 8'h03, 1'b1);
        chk("R9 pin_oe", pin_oe, 8'h03);
        chk("R9 pin_out", pin_out, 8'h03);
        pin_in = 8'hF0;
        bus_read(16'h4800);
        chk("R10 mixed read with strap", cpu_rdata, 8'hF3);
        bus_read(16'h4801);
        chk("R9 dir read", cpu_rdata, 8'h03);
        pin_in = 8'hFF;

        // R6 clear override by port
        bus_write(16'h4800, 8'h01, 1'b1);
        bus_read(16'hFFFC);
        chk("R6 cart visible", con_en, 1'b1);
        chk("R6 addr passthru", con_addr, 16'hFFFC);
        bus_read(16'h1234);
        chk("R6 rom decode kept", rom_sel, 1'b1);
        bus_write(16'h4800, 8'h03, 1'b1);
        bus_read(16'hFFFC);
        chk("R6 override back", rom_sel, 1'b1);

        // R12 write without M2 ignored
        bus_write(16'h4800, 8'h00, 1'b0);
        chk("R12 no write m2 low", pin_out, 8'h03);

        // R5 lockout
        bus_write(16'h4800, 8'h02, 1'b1);
        chk("R5 pin_out", pin_out, 8'h02);
        bus_read(16'h1234);
        chk("R5 rom off", rom_sel, 1'b0);
        chk("R5 con_addr", con_addr, 16'h1234);
        bus_read(16'hFFFC);
        chk("R5 override off", con_en, 1'b1);
        bus_read(16'h4800);
        chk("R5 port off", port_sel, 1'b0);
        bus_write(16'h4801, 8'h00, 1'b1);
        chk("R5 write ignored", pin_oe, 8'h03);
        bus_read(16'h1234);
        chk("R5 still locked", rom_sel, 1'b0);

        // R3 reset restores decoding
        do_reset();
        chk("R3 pin_oe after reset", pin_oe, 8'h00);
        bus_read(16'h1234);
        chk("R3 rom back", rom_sel, 1'b1);
        bus_read(16'hFFFC);
        chk("R3 override back", rom_sel, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule